// File: doc/BRIEF.md
# Online Entropy Health Monitor

This block sits beside a random number source and watches two things at once: the serial raw bit stream that feeds the conditioner, and the wide output words that the source delivers. It checks the stream while it runs. It flags a statistical imbalance, runs of identical bits that are too long, and an output word that repeats.

Four detectors work side by side, and each detector owns one sticky failure flag. The monobit detector frames the bit stream into fixed-size blocks and counts the ones in each block. One run-length counter serves two detectors, a long-run detector and a noise detector, which fire at two different run thresholds. The stuck-output detector compares each output word with the word that came before it. The flags stay set until the system pulses the clear input. The surrounding logic typically gates output delivery on these flags or restarts the source when they are set.

Top module: `entropy_health_mon`

## Requirements
- R1: While rst_n is low at a clock edge, all four fail flags are 0 after that edge, and the block framing, ones count, run length and stored word history all restart, so the first bit after reset is bit 0 of a new block.
- R2: After each BLOCK_BITS accepted bits, the ones count of that block is judged. fail_mono is set after the edge that accepts the final bit if the count is at most MONO_LO or at least MONO_HI. It stays clear if the count lies strictly between the two bounds.
- R3: The block bit counter and ones counter restart at each block boundary. Every block is judged only on its own bits, and no judgement is made before a block is complete.
- R4: The run length becomes 1 whenever an accepted bit differs from the previous accepted bit, and grows by one when the bit repeats. fail_long is set after the edge at which the run length reaches LONG_RUN. A run of LONG_RUN-1 never sets it.
- R5: fail_noise is set after the edge at which the same run length reaches NOISE_RUN, and a run of NOISE_RUN-1 never sets it. NOISE_RUN is at least LONG_RUN, so fail_long is always set together with fail_noise.
- R6: Runs are counted across block boundaries. A run that straddles two blocks counts its full length.
- R7: fail_stuck is set after the edge that accepts an output word equal to the word accepted just before it.
- R8: The first output word accepted after reset is never compared, so it cannot set fail_stuck, whatever its value.
- R9: Each fail flag stays 1 until an edge with clear high, which makes it 0. If a failure event and clear occur at the same edge, the flag is 1 afterwards.
- R10: bit_in is ignored when bit_valid is 0, and word_in is ignored when word_valid is 0. Such cycles change no counter, run or stored word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_valid | input | 1 | bit_in carries a raw bit this cycle |
| bit_in | input | 1 | Serial raw random bit |
| word_valid | input | 1 | word_in carries an output word this cycle |
| word_in | input | WORD_W | Output word from the source |
| clear | input | 1 | Clears all fail flags at the edge |
| fail_mono | output | 1 | Sticky monobit failure |
| fail_long | output | 1 | Sticky long-run failure |
| fail_noise | output | 1 | Sticky noise (very long run) failure |
| fail_stuck | output | 1 | Sticky repeated-output-word failure |

## Verification
The properties assume that clear is a level that is sampled on each edge, and that a flag can rise only after an edge that accepted a bit or a word. They also assume that NOISE_RUN is not below LONG_RUN, so the noise flag never rises without the long-run flag. The bench uses a reduced configuration: 16-bit blocks, bounds 5 and 11, run thresholds 5 and 7, and 8-bit words. It changes its inputs only on falling edges, and it asserts reset only between stimulus phases. It sweeps every ones count in a block and every run length up to past the noise threshold, so that every flag rises for a reason the properties accept.

// File: rtl/ehm_pkg.sv
// Package: shared indices for the health monitor's failure event and flag vectors.
// Assumes: every detector reports a one-cycle event at a fixed index.
package ehm_pkg;
    localparam int FAIL_MONO  = 0;
    localparam int FAIL_LONG  = 1;
    localparam int FAIL_NOISE = 2;
    localparam int FAIL_STUCK = 3;
    localparam int NUM_FAIL   = 4;
endpackage

// File: rtl/ehm_monobit.sv
// Module: frames accepted bits into blocks of BLOCK_BITS and pulses bad_evt
// when a finished block's ones count is not strictly between LO and HI.
// Assumes: LO < HI <= BLOCK_BITS, BLOCK_BITS >= 2.
module ehm_monobit #(
    parameter int BLOCK_BITS = 20000,
    parameter int LO         = 9655,
    parameter int HI         = 10345
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_valid,
    input  logic bit_in,
    output logic bad_evt
);
    localparam int IW = $clog2(BLOCK_BITS);
    localparam int OW = $clog2(BLOCK_BITS + 1);
    localparam logic [IW-1:0] LAST_IDX = IW'(BLOCK_BITS - 1);
    localparam logic [OW-1:0] LO_V     = OW'(LO);
    localparam logic [OW-1:0] HI_V     = OW'(HI);

    logic [IW-1:0] idx;
    logic [OW-1:0] ones;
    logic [OW-1:0] ones_nx;
    logic          blk_end;

    // Next ones count and block-end detection for the bit accepted this cycle.
    always_comb begin
        ones_nx = ones + OW'(bit_in);
        blk_end = bit_valid && (idx == LAST_IDX);
        bad_evt = blk_end && ((ones_nx <= LO_V) || (ones_nx >= HI_V));
    end

    // Bit position and ones count within the current block.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx  <= '0;
            ones <= '0;
        end else if (bit_valid) begin
            if (blk_end) begin
                idx  <= '0;
                ones <= '0;
            end else begin
                idx  <= idx + 1'b1;
                ones <= ones_nx;
            end
        end
    end
endmodule

// File: rtl/ehm_runlen.sv
// Module: one run-length counter over accepted bits, with two threshold events.
// Assumes: 1 <= LONG_RUN <= NOISE_RUN; runs continue across block boundaries.
module ehm_runlen #(
    parameter int LONG_RUN  = 34,
    parameter int NOISE_RUN = 48
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_valid,
    input  logic bit_in,
    output logic long_evt,
    output logic noise_evt
);
    localparam int RUN_MAX = (NOISE_RUN > LONG_RUN) ? NOISE_RUN : LONG_RUN;
    localparam int RW      = $clog2(RUN_MAX + 1);
    localparam logic [RW-1:0] MAX_V   = RW'(RUN_MAX);
    localparam logic [RW-1:0] LONG_V  = RW'(LONG_RUN);
    localparam logic [RW-1:0] NOISE_V = RW'(NOISE_RUN);

    logic [RW-1:0] run;
    logic [RW-1:0] run_nx;
    logic          last_bit;
    logic          have_bit;

    // Run length after the current bit, saturating at the largest threshold.
    always_comb begin
        if (!have_bit || (bit_in != last_bit))
            run_nx = RW'(1);
        else if (run == MAX_V)
            run_nx = run;
        else
            run_nx = run + 1'b1;
        long_evt  = bit_valid && (run_nx >= LONG_V);
        noise_evt = bit_valid && (run_nx >= NOISE_V);
    end

    // Run length and the value of the last accepted bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run      <= '0;
            last_bit <= 1'b0;
            have_bit <= 1'b0;
        end else if (bit_valid) begin
            run      <= run_nx;
            last_bit <= bit_in;
            have_bit <= 1'b1;
        end
    end
endmodule

// File: rtl/ehm_stuck.sv
// Module: pulses rep_evt when an accepted word equals the previously accepted word.
// Assumes: the first word after reset has no predecessor and is never compared.
module ehm_stuck #(
    parameter int WORD_W = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word_in,
    output logic              rep_evt
);
    logic [WORD_W-1:0] prev;
    logic              have_prev;

    // Repeat detection against the stored predecessor.
    always_comb rep_evt = word_valid && have_prev && (word_in == prev);

    // Holds the last accepted word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev      <= '0;
            have_prev <= 1'b0;
        end else if (word_valid) begin
            prev      <= word_in;
            have_prev <= 1'b1;
        end
    end
endmodule

// File: rtl/ehm_sticky.sv
// Module: one sticky flag; a set event outranks a clear at the same edge.
// Assumes: set and clr are sampled once per clock.
module ehm_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);
    // Set-dominant sticky latch of a failure event.
    always_ff @(posedge clk) begin
        if (!rst_n)   flag <= 1'b0;
        else if (set) flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end
endmodule

// File: rtl/entropy_health_mon.sv
// Module: top of the online health monitor; four detectors feed four sticky flags.
// Assumes: MONO_LO < MONO_HI <= BLOCK_BITS and LONG_RUN <= NOISE_RUN.
module entropy_health_mon #(
    parameter int BLOCK_BITS = 20000,
    parameter int MONO_LO    = 9655,
    parameter int MONO_HI    = 10345,
    parameter int LONG_RUN   = 34,
    parameter int NOISE_RUN  = 48,
    parameter int WORD_W     = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_valid,
    input  logic              bit_in,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word_in,
    input  logic              clear,
    output logic              fail_mono,
    output logic              fail_long,
    output logic              fail_noise,
    output logic              fail_stuck
);
    import ehm_pkg::*;

    logic [NUM_FAIL-1:0] evt;
    logic [NUM_FAIL-1:0] flags;

    ehm_monobit #(.BLOCK_BITS(BLOCK_BITS), .LO(MONO_LO), .HI(MONO_HI)) u_mono (
        .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_in(bit_in),
        .bad_evt(evt[FAIL_MONO])
    );

    ehm_runlen #(.LONG_RUN(LONG_RUN), .NOISE_RUN(NOISE_RUN)) u_run (
        .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_in(bit_in),
        .long_evt(evt[FAIL_LONG]), .noise_evt(evt[FAIL_NOISE])
    );

    ehm_stuck #(.WORD_W(WORD_W)) u_stuck (
        .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .word_in(word_in),
        .rep_evt(evt[FAIL_STUCK])
    );

    for (genvar g = 0; g < NUM_FAIL; g++) begin : g_flag
        ehm_sticky u_flag (
            .clk(clk), .rst_n(rst_n), .set(evt[g]), .clr(clear), .flag(flags[g])
        );
    end

    assign fail_mono  = flags[FAIL_MONO];
    assign fail_long  = flags[FAIL_LONG];
    assign fail_noise = flags[FAIL_NOISE];
    assign fail_stuck = flags[FAIL_STUCK];
endmodule

// File: rtl/ehm_checker.sv
// Checker: temporal properties on the monitor's ports, bound into the top.
module ehm_checker (
    input logic clk,
    input logic rst_n,
    input logic bit_valid,
    input logic word_valid,
    input logic clear,
    input logic fail_mono,
    input logic fail_long,
    input logic fail_noise,
    input logic fail_stuck
);
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> !(fail_mono || fail_long || fail_noise || fail_stuck));

    p_mono_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fail_mono) |-> $past(bit_valid));

    p_long_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fail_long) |-> $past(bit_valid));

    p_noise_long_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fail_noise) |-> fail_long);

    p_stuck_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fail_stuck) |-> $past(word_valid));

    p_sticky_mono_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fail_mono && !clear |=> fail_mono);

    p_sticky_long_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fail_long && !clear |=> fail_long);

    p_sticky_noise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fail_noise && !clear |=> fail_noise);

    p_sticky_stuck_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fail_stuck && !clear |=> fail_stuck);
endmodule

bind entropy_health_mon ehm_checker u_chk (
    .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .word_valid(word_valid),
    .clear(clear), .fail_mono(fail_mono), .fail_long(fail_long),
    .fail_noise(fail_noise), .fail_stuck(fail_stuck)
);

// File: tb/entropy_health_mon_test.sv
module entropy_health_mon_test;
    localparam int CLK_PERIOD = 10;
    localparam int BLK = 16;
    localparam int LO  = 5;
    localparam int HI  = 11;
    localparam int LNG = 5;
    localparam int NSE = 7;
    localparam int WW  = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bit_valid = 1'b0;
    logic          bit_in = 1'b0;
    logic          word_valid = 1'b0;
    logic [WW-1:0] word_in = '0;
    logic          clear = 1'b0;
    logic          fail_mono, fail_long, fail_noise, fail_stuck;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    entropy_health_mon #(
        .BLOCK_BITS(BLK), .MONO_LO(LO), .MONO_HI(HI),
        .LONG_RUN(LNG), .NOISE_RUN(NSE), .WORD_W(WW)
    ) uut (
        .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_in(bit_in),
        .word_valid(word_valid), .word_in(word_in), .clear(clear),
        .fail_mono(fail_mono), .fail_long(fail_long),
        .fail_noise(fail_noise), .fail_stuck(fail_stuck)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bit_valid = 1'b0; word_valid = 1'b0; clear = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic send_bit(input logic b);
        bit_valid = 1'b1; bit_in = b;
        @(negedge clk);
        bit_valid = 1'b0;
    endtask

    task automatic send_word(input logic [WW-1:0] w, input logic with_clear);
        word_valid = 1'b1; word_in = w; clear = with_clear;
        @(negedge clk);
        word_valid = 1'b0; clear = 1'b0;
    endtask

    task automatic pulse_clear();
        clear = 1'b1;
        @(negedge clk);
        clear = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        // R1: reset state, sampled while reset is held.
        @(negedge clk); @(negedge clk);
        chk("R1 mono", fail_mono, 1'b0);
        chk("R1 long", fail_long, 1'b0);
        chk("R1 noise", fail_noise, 1'b0);
        chk("R1 stuck", fail_stuck, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset mid-block restarts framing; an alternating block then passes.
        for (int i = 0; i < 10; i++) send_bit(1'b1);
        do_reset();
        for (int i = 0; i < BLK; i++) begin
            send_bit(logic'((i % 2) == 0));
            if (i == 5) chk("R1 framing restarted", fail_mono, 1'b0);
        end
        chk("R1 block after reset passes", fail_mono, 1'b0);

        // R2/R3: sweep every ones count; ones placed first, zeros after.
        for (int k = 0; k <= BLK; k++) begin
            pulse_clear();
            for (int i = 0; i < BLK; i++) begin
                send_bit(logic'(i < k));
                if (i == BLK - 2) chk("R3 no verdict before block end", fail_mono, 1'b0);
            end
            chk("R2 monobit verdict", fail_mono, logic'((k <= LO) || (k >= HI)));
        end

        // R4/R5: sweep run lengths 1..9 of ones, each preceded by a zero.
        for (int len = 1; len <= 9; len++) begin
            send_bit(1'b0);
            pulse_clear();
            for (int i = 0; i < len; i++) send_bit(1'b1);
            chk("R4 long run", fail_long, logic'(len >= LNG));
            chk("R5 noise run", fail_noise, logic'(len >= NSE));
            send_bit(1'b0);
            chk("R4 run resets on change", fail_long, logic'(len >= LNG));
        end

        // R6: a run of LNG+1 ones straddling a block boundary.
        do_reset();
        for (int i = 0; i < 13; i++) send_bit(logic'((i % 2) == 1));
        for (int i = 0; i < LNG + 1; i++) send_bit(1'b1);
        chk("R6 run across boundary", fail_long, 1'b1);

        // R10: bit_in toggling while bit_valid is low does not break a run.
        do_reset();
        send_bit(1'b0);
        for (int i = 0; i < LNG - 1; i++) send_bit(1'b1);
        for (int i = 0; i < 6; i++) begin
            bit_in = logic'(i % 2);
            @(negedge clk);
        end
        chk("R10 idle bits ignored", fail_long, 1'b0);
        send_bit(1'b1);
        chk("R10 run continued", fail_long, 1'b1);

        // R8: first word after reset equals the reset history value.
        do_reset();
        send_word('0, 1'b0);
        chk("R8 first word not compared", fail_stuck, 1'b0);
        send_word('0, 1'b0);
        chk("R7 repeat flagged", fail_stuck, 1'b1);
        pulse_clear();
        chk("R9 clear", fail_stuck, 1'b0);

        // R7: sweep of distinct consecutive words, then a repeat.
        for (int w = 1; w < 40; w++) begin
            send_word(WW'(w * 7), 1'b0);
            chk("R7 distinct word", fail_stuck, 1'b0);
        end
        // R10: a repeated word on the bus while word_valid is low.
        word_in = WW'(39 * 7);
        repeat (4) @(negedge clk);
        chk("R10 idle word ignored", fail_stuck, 1'b0);
        send_word(WW'(39 * 7), 1'b0);
        chk("R7 repeat after sweep", fail_stuck, 1'b1);

        // R9: flag holds without clear; a set at the same edge as clear wins.
        repeat (5) @(negedge clk);
        chk("R9 sticky hold", fail_stuck, 1'b1);
        send_word(WW'(39 * 7), 1'b1);
        chk("R9 set beats clear", fail_stuck, 1'b1);
        send_word(WW'(3), 1'b1);
        chk("R9 clear with distinct word", fail_stuck, 1'b0);

        summary();
    end
endmodule